// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is a clocked model of the write path of a byte-wide memory whose array is organised in 64-byte pages. A fast system clock samples three active-low strobes (chip select, write strobe, output enable), an address bus and a data bus. Every qualified write strobe places one byte into a page holding buffer. Each byte also marks its position as loaded.

A load stays open while new bytes keep arriving within a fixed window. When the window runs out, a self-timed programming phase copies only the marked positions into the array. During this phase the array cannot be read and no write is taken. A plain synchronous RAM stands in for the array. All time limits are counts of clock cycles, so a bench can shrink them.

Top module: `nvm_page_writer`

## Requirements
- R1: While rst_ni is low, busy_o, loading_o, page_err_o, ready_o and rd_valid_o are all 0.
- R2: ready_o rises POR_CYC cycles after reset is released and then stays high. Any write strobe given before ready_o is high is dropped, and no load opens.
- R3: A write is taken when ce_ni and we_ni are both low and oe_ni is high for at least MIN_PULSE sampled cycles. The address is the one sampled in the first cycle of that overlap. The data is the one sampled in its last cycle.
- R4: A strobe overlap that ends with oe_ni low writes nothing. So does an overlap shorter than MIN_PULSE samples.
- R5: A byte that arrives within BLC_CYC cycles of the previous accepted byte joins the open load, and loading_o stays high. Programming starts (busy_o rises) once BLC_CYC cycles pass with no further byte in the page.
- R6: The page is given by the address bits above the low OFF_W bits, and the first byte of a load fixes it. A later byte for another page is dropped and sets page_err_o. That load goes on unchanged, and page_err_o clears when the next load opens.
- R7: Bytes within the page may arrive in any order. A position written twice in one load keeps the later value.
- R8: Programming writes only the positions loaded in that load. Every other byte of the page keeps its earlier value.
- R9: busy_o stays high for exactly PROG_CYC cycles per load. Write strobes during that time are dropped.
- R10: A read request (ce_ni low, oe_ni low, we_ni high) sampled while the block is not programming gives rd_valid_o high with the array byte at the sampled address. This appears two clock edges after the request is driven. Requests made during programming give rd_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address; upper bits select the page, low OFF_W bits select the byte |
| data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Array byte from the last valid read |
| rd_valid_o | output | 1 | rd_data_o holds a fresh read result |
| loading_o | output | 1 | A page load is open |
| busy_o | output | 1 | Self-timed programming in progress |
| page_err_o | output | 1 | A byte outside the open page was dropped in this load |
| ready_o | output | 1 | Power-on delay has elapsed |

## Verification
The page is first filled in full and in order, which checks that every position gets written. Then a sparse load with out-of-order bytes and one position written twice shows both selective commit and last-value-wins: the untouched neighbours must still hold the old fill. Pulses that move address and data mid-overlap, drop oe_ni before the end, or are too short tell apart the capture points and the inhibit rules. A byte for a foreign page, a write during programming and two bytes spaced just inside the window show, in turn, page locking, busy lockout and window renewal.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int PAGE_OFF_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } wr_state_e;
endpackage

// File: rtl/nvm_strobe.sv
module nvm_strobe #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  localparam int PLEN_W = $clog2(MIN_PULSE + 1) + 1;

  logic              ce_q, we_q, oe_q, act_d;
  logic [ADDR_W-1:0] addr_q, addr_lat;
  logic [DATA_W-1:0] data_q, data_lat;
  logic [PLEN_W-1:0] plen_q;
  logic              act;

  assign act = ~ce_q & ~we_q & oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q     <= 1'b1;
      we_q     <= 1'b1;
      oe_q     <= 1'b1;
      act_d    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      addr_lat <= '0;
      data_lat <= '0;
      plen_q   <= '0;
    end else begin
      ce_q   <= ce_ni;
      we_q   <= we_ni;
      oe_q   <= oe_ni;
      addr_q <= addr_i;
      data_q <= data_i;
      act_d  <= act;
      if (act && !act_d) begin
        plen_q   <= PLEN_W'(1);
        addr_lat <= addr_q;            // later of the two falling strobes
      end else if (act && plen_q < PLEN_W'(MIN_PULSE)) begin
        plen_q <= plen_q + 1'b1;
      end
      if (act) data_lat <= data_q;     // value held at the first rising strobe
    end
  end

  // overlap ended by a strobe rising, with output enable still high
  assign wr_stb_o  = act_d & ~act & oe_q & (plen_q >= PLEN_W'(MIN_PULSE));
  assign wr_addr_o = addr_lat;
  assign wr_data_o = data_lat;
  assign rd_req_o  = ~ce_q & ~oe_q & we_q;
  assign rd_addr_o = addr_q;
endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  localparam int NBYTES = 1 << OFF_W;

  logic [DATA_W-1:0] byte_q [NBYTES];
  logic [NBYTES-1:0] vld_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en_i && wr_off_i == OFF_W'(g)) begin
        byte_q[g] <= wr_data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = byte_q[rd_off_i];
  assign rd_vld_o  = vld_q[rd_off_i];
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = PAGE_OFF_W,
  parameter int MIN_PULSE = 2,
  parameter int BLC_CYC   = 5000,
  parameter int PROG_CYC  = 500000,
  parameter int POR_CYC   = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              loading_o,
  output logic              busy_o,
  output logic              page_err_o,
  output logic              ready_o
);
  localparam int PG_W       = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int TMR_W      = $clog2(BLC_CYC + 1);
  localparam int PCNT_W     = $clog2(PROG_CYC + 1);
  localparam int POR_W      = $clog2(POR_CYC + 1);

  logic              wr_stb, rd_req;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, buf_data;
  logic              buf_vld, buf_we, buf_clr, arr_we, accept, same_pg, in_walk;

  wr_state_e         state_q;
  logic [PG_W-1:0]   page_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [POR_W-1:0]  por_q;
  logic              err_q, ready_q, rd_vld_q;

  nvm_strobe #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
  ) u_strobe (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr)
  );

  assign accept  = wr_stb & ready_q & (state_q != ST_PROG);
  assign same_pg = wr_addr[ADDR_W-1:OFF_W] == page_q;
  assign buf_we  = accept & ((state_q == ST_IDLE) | ((state_q == ST_LOAD) & same_pg));
  assign in_walk = (state_q == ST_PROG) && (pcnt_q < PCNT_W'(PAGE_BYTES));
  assign buf_clr = (state_q == ST_PROG) && (pcnt_q == PCNT_W'(PROG_CYC - 1));
  assign arr_we  = in_walk & buf_vld;

  nvm_page_buf #(
    .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i(buf_we), .wr_off_i(wr_addr[OFF_W-1:0]), .wr_data_i(wr_data),
    .clr_i(buf_clr), .rd_off_i(pcnt_q[OFF_W-1:0]),
    .rd_data_o(buf_data), .rd_vld_o(buf_vld)
  );

  nvm_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_array (
    .clk_i,
    .we_i(arr_we), .waddr_i({page_q, pcnt_q[OFF_W-1:0]}), .wdata_i(buf_data),
    .raddr_i(rd_addr), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      tmr_q    <= '0;
      pcnt_q   <= '0;
      err_q    <= 1'b0;
      por_q    <= '0;
      ready_q  <= 1'b0;
      rd_vld_q <= 1'b0;
    end else begin
      if (!ready_q) begin
        if (por_q == POR_W'(POR_CYC - 1)) ready_q <= 1'b1;
        else por_q <= por_q + 1'b1;
      end
      rd_vld_q <= rd_req & (state_q != ST_PROG);
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LOAD;
          page_q  <= wr_addr[ADDR_W-1:OFF_W];
          tmr_q   <= '0;
          err_q   <= 1'b0;
        end
        ST_LOAD: begin
          if (accept && !same_pg) err_q <= 1'b1;
          if (accept && same_pg) begin
            tmr_q <= '0;
          end else if (tmr_q == TMR_W'(BLC_CYC - 1)) begin
            state_q <= ST_PROG;
            pcnt_q  <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (buf_clr) state_q <= ST_IDLE;
          else pcnt_q <= pcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid_o = rd_vld_q;
  assign loading_o  = state_q == ST_LOAD;
  assign busy_o     = state_q == ST_PROG;
  assign page_err_o = err_q;
  assign ready_o    = ready_q;
endmodule

// File: rtl/nvm_page_writer_chk.sv
module nvm_page_writer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_valid_o,
  input logic loading_o,
  input logic busy_o,
  input logic page_err_o,
  input logic ready_o
);
  AST_LOAD_PROG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && loading_o)); // R9
  AST_NO_READ_IN_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o); // R10
  AST_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R2
  AST_QUIET_BEFORE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (!loading_o && !busy_o)); // R2
  AST_PROG_FOLLOWS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(loading_o)); // R5
  AST_ERR_DURING_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(page_err_o) |-> (loading_o || busy_o)); // R6
endmodule

bind nvm_page_writer nvm_page_writer_chk u_chk (.*);

// File: tb/tb_nvm_page_writer.sv
module tb_nvm_page_writer;
  localparam int AW   = 11;
  localparam int BLC  = 40;
  localparam int PRG  = 100;
  localparam int POR  = 30;
  localparam int MINP = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] rd_data_o;
  logic rd_valid_o, loading_o, busy_o, page_err_o, ready_o;

  nvm_page_writer #(
    .ADDR_W(AW), .DATA_W(8), .MIN_PULSE(MINP),
    .BLC_CYC(BLC), .PROG_CYC(PRG), .POR_CYC(POR)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .rd_data_o, .rd_valid_o, .loading_o,
    .busy_o, .page_err_o, .ready_o
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  int model_mem [2048];
  int pend_a [$];
  int pend_d [$];
  bit prev_req = 1'b0;
  int prev_a = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d, int len = 4);
    @(negedge clk);
    addr = AW'(a); din = 8'(d); oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (len - 1) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wrp(int a, int d);
    wr(a, d);
    pend_a.push_back(a);
    pend_d.push_back(d);
  endtask

  task automatic apply_pend();
    foreach (pend_a[i]) model_mem[pend_a[i]] = pend_d[i];
    pend_a.delete();
    pend_d.delete();
  endtask

  task automatic rd_chk(int a, string tag);
    @(negedge clk);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rd_valid_o == 1'b1, {tag, " valid"}, int'(rd_valid_o), 1);
    chk(int'(rd_data_o) == model_mem[a], {tag, " data"}, int'(rd_data_o), model_mem[a]);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_busy_fall();
    int n = 0;
    while (busy_o && n < PRG + 50) begin
      n++;
      @(negedge clk);
    end
    apply_pend();
  endtask

  task automatic wait_prog(string tag);
    int w = 0;
    int n = 0;
    while (!busy_o && w < BLC + 50) begin
      w++;
      @(negedge clk);
    end
    chk(busy_o == 1'b1, {tag, " R5 programming starts"}, int'(busy_o), 1);
    while (busy_o && n < PRG + 50) begin
      n++;
      @(negedge clk);
    end
    chk(n == PRG, {tag, " R9 busy length"}, n, PRG);
    apply_pend();
  endtask

  // per-clock reference compare of the read port (R10)
  always @(posedge clk) begin
    #2;
    if (rst_n && rd_valid_o) begin
      chk(prev_req, "R10 valid without request", int'(rd_valid_o), 0);
      if (prev_req && model_mem[prev_a] >= 0)
        chk(int'(rd_data_o) == model_mem[prev_a], "R10 read data", int'(rd_data_o), model_mem[prev_a]);
    end
    prev_req = !ce_n && !oe_n && we_n;
    prev_a = int'(addr);
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (model_mem[i]) model_mem[i] = -1;
    repeat (3) @(negedge clk);
    chk({busy_o, loading_o, page_err_o, ready_o, rd_valid_o} == 5'b0, "R1 reset outputs",
        int'({busy_o, loading_o, page_err_o, ready_o, rd_valid_o}), 0);
    rst_n = 1'b1;

    // R2: power-on lockout
    @(negedge clk);
    chk(ready_o == 1'b0, "R2 not ready early", int'(ready_o), 0);
    wr(5, 8'h77);
    repeat (3) @(negedge clk);
    chk(loading_o == 1'b0, "R2 early write dropped", int'(loading_o), 0);
    for (int i = 0; i < POR + 10 && !ready_o; i++) @(negedge clk);
    chk(ready_o == 1'b1, "R2 ready after delay", int'(ready_o), 1);

    // full page fill, in order (page 3)
    for (int i = 0; i < 64; i++) wrp(192 + i, (i ^ 8'hA5) & 8'hFF);
    wait_prog("fill");
    for (int i = 0; i < 64; i++) rd_chk(192 + i, "R8 fill");

    // R7/R8: sparse, out of order, with a rewrite
    wrp(202, 8'h10);
    wrp(194, 8'h21);
    wrp(232, 8'h40);
    wrp(194, 8'h5A);
    wait_prog("sparse");
    rd_chk(194, "R7 last value wins");
    rd_chk(202, "R7 out of order");
    for (int i = 0; i < 64; i++) rd_chk(192 + i, "R8 untouched kept");

    // R3: address taken at overlap start, data at overlap end
    @(negedge clk);
    addr = AW'(212); din = 8'h01; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = AW'(213); din = 8'h02;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    pend_a.push_back(212); pend_d.push_back(8'h02);
    wait_prog("capture");
    rd_chk(212, "R3 start address end data");
    rd_chk(213, "R3 later address unused");

    // R4: oe low at end of overlap, and too-short pulse
    @(negedge clk);
    addr = AW'(222); din = 8'hEE; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    oe_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(loading_o == 1'b0, "R4 oe inhibit", int'(loading_o), 0);
    wr(223, 8'hEF, 2);
    repeat (4) @(negedge clk);
    chk(loading_o == 1'b0, "R4 short pulse", int'(loading_o), 0);
    rd_chk(222, "R4 inhibited byte");
    rd_chk(223, "R4 short byte");

    // R6: foreign page byte dropped
    wrp(385, 8'h11);
    wait_prog("pre6");
    wrp(449, 8'h44);
    wait_prog("pre7");
    wrp(321, 8'h51);
    wr(385, 8'h99);
    repeat (2) @(negedge clk);
    chk(page_err_o == 1'b1, "R6 flag set", int'(page_err_o), 1);
    chk(loading_o == 1'b1, "R6 load continues", int'(loading_o), 1);
    wrp(322, 8'h52);
    wait_prog("pageerr");
    rd_chk(321, "R6 first byte");
    rd_chk(322, "R6 byte after error");
    rd_chk(385, "R6 foreign byte dropped");

    // R9/R10: lockout during programming
    wrp(448, 8'h22);
    repeat (2) @(negedge clk);
    chk(page_err_o == 1'b0, "R6 flag cleared on new load", int'(page_err_o), 0);
    for (int i = 0; i < BLC + 20 && !busy_o; i++) @(negedge clk);
    chk(busy_o == 1'b1, "R9 busy reached", int'(busy_o), 1);
    wr(449, 8'h33);
    @(negedge clk);
    addr = AW'(448); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_valid_o == 1'b0, "R10 no read while busy", int'(rd_valid_o), 0);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_busy_fall();
    repeat (4) @(negedge clk);
    chk(loading_o == 1'b0, "R9 busy-time write dropped", int'(loading_o), 0);
    rd_chk(449, "R9 byte unchanged");
    rd_chk(448, "R9 committed byte");

    // R5: window renewal and timeout
    wrp(512, 8'h61);
    repeat (BLC - 10) @(negedge clk);
    wrp(513, 8'h62);
    repeat (BLC - 6) @(negedge clk);
    chk(loading_o == 1'b1 && busy_o == 1'b0, "R5 window renewed",
        int'({loading_o, busy_o}), 2);
    repeat (10) @(negedge clk);
    chk(busy_o == 1'b1, "R5 timeout starts programming", int'(busy_o), 1);
    wait_busy_fall();
    rd_chk(512, "R5 first byte");
    rd_chk(513, "R5 second byte");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule